// File: doc/BRIEF.md
# Priority Reference Selection Controller

This block decides how a clock synchronizer runs. Each cycle it takes one qualified flag per reference input, a mask, a priority value per reference and a priority value for Free Run. From these it chooses one of three operating states: Free Run, Hold Over, or Locked to a particular reference. It also reports the index of the active reference, raises an alarm when the locked reference is lost, and pulses a strobe for one cycle whenever the state or the active reference changes. The phase-locked loop and holdover averaging that act on this decision are outside the block.

Two control styles are supported. In manual mode the operator names the state and the reference. In autonomous mode the block ranks the usable candidates on its own. Autonomous selection can be revertive, which returns to a better candidate once that candidate has stayed best for a programmed number of minutes. It can also be non-revertive, which stays on the current choice for as long as that choice remains usable. Free Run can take part in the ranking as if it were a reference. When nothing can be used, a holdover-available input chooses between Hold Over and Free Run.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted the outputs are: state Free Run, active reference 0, alarm low, strobe low. The state encoding is 0 = Free Run, 1 = Hold Over, 2 = Locked.
- R2: A reference is available when its qualified bit is 1 and its mask bit is 0 (a mask bit of 1 removes the reference). An unavailable reference is never entered or kept in the Locked state.
- R3: In autonomous mode the chosen candidate is the available reference with the smallest nonzero priority value, where 1 is the best. On equal priority the lower index wins. Priority 0 is never selected.
- R4: A nonzero Free Run priority enters Free Run into the same ranking. On a tie, a reference beats Free Run. When Free Run wins, the state is Free Run.
- R5: In autonomous mode with no candidate at all, the state is Hold Over if the holdover-available input is 1 and Free Run otherwise. This choice is re-evaluated every cycle.
- R6: In autonomous mode, when the current selection stops being usable, the block moves to the best remaining candidate one clock after the inputs change.
- R7: With reversion disabled, a usable current selection is kept even when a better candidate exists.
- R8: With reversion enabled, the block moves to a better candidate once that same candidate has been best for the programmed number of minute ticks. A delay of 0 moves on the next clock.
- R9: The reversion wait restarts from zero whenever the better candidate drops out or a different candidate becomes best.
- R10: One minute tick equals TICK_DIV clock cycles. A delay of D therefore takes between D*TICK_DIV and D*TICK_DIV+2 clocks.
- R11: In manual mode the requested state is applied one clock later: code 0 gives Free Run, 1 gives Hold Over, 3 gives Hold Over, and 2 locks to the requested reference if that reference is available. Priorities are ignored in manual mode. A lock request to an unavailable reference gives Hold Over.
- R12: The alarm sets when the locked reference becomes unavailable, or when a manual lock request names an unavailable reference. It clears when the block next locks.
- R13: The strobe is high for exactly the first cycle in which the state or the active reference shows a new value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_qual_i | input | NREF | Per-reference qualified flags |
| ref_mask_i | input | NREF | Per-reference removal mask, 1 removes |
| ref_prio_i | input | NREF*PRIO_W | Packed priorities, reference i in bits [i*PRIO_W +: PRIO_W] |
| fr_prio_i | input | PRIO_W | Free Run priority, 0 keeps it out of the ranking |
| auto_mode_i | input | 1 | 1 autonomous, 0 manual |
| revert_en_i | input | 1 | Revertive switching enable |
| rev_delay_i | input | DLY_W | Reversion wait in minute ticks |
| man_state_i | input | 2 | Manual state request |
| man_ref_i | input | IDX_W | Manual reference request |
| hold_ok_i | input | 1 | Hold Over data is usable |
| state_o | output | 2 | Operating state |
| active_ref_o | output | IDX_W | Index of the reference last locked to |
| los_o | output | 1 | Loss-of-reference alarm |
| change_o | output | 1 | One-cycle strobe on a state or reference change |

## Verification
The bench sweeps all 256 qualified patterns against priority tables that contain zeros, ties and a masked entry, with and without a Free Run entry. A design that ranks ties by the higher index, lets Free Run win a tie, or accepts priority 0 selects the wrong reference on some of these patterns. Directed runs measure the reversion wait to within two clocks on each side and interrupt a wait part way through. A timer that counts one tick too many or too few, or that fails to restart, switches at the wrong moment. Manual requests to masked references and the loss of a locked reference check that the alarm sets and clears, and that the strobe lasts exactly one cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    OP_FREERUN  = 2'd0,
    OP_HOLDOVER = 2'd1,
    OP_LOCKED   = 2'd2
  } op_state_e;
endpackage

// File: rtl/refsel_pick.sv
// Ranks eligible references plus an optional Free Run entry.
module refsel_pick #(
  parameter int NREF   = 8,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 4
) (
  input  logic [NREF-1:0]   elig_i,
  input  logic [PRIO_W-1:0] prio_i [NREF],
  input  logic [PRIO_W-1:0] fr_prio_i,
  output logic              found_o,
  output logic [SEL_W-1:0]  best_o
);
  localparam logic [SEL_W-1:0] FR_SEL = SEL_W'(NREF);

  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    found_o   = 1'b0;
    best_o    = '0;
    best_prio = '0;
    // strict compare keeps the lower index on ties
    for (int i = 0; i < NREF; i++) begin
      if (elig_i[i] && (!found_o || (prio_i[i] < best_prio))) begin
        found_o   = 1'b1;
        best_o    = SEL_W'(i);
        best_prio = prio_i[i];
      end
    end
    // Free Run loses ties against references
    if ((fr_prio_i != '0) && (!found_o || (fr_prio_i < best_prio))) begin
      found_o   = 1'b1;
      best_o    = FR_SEL;
      best_prio = fr_prio_i;
    end
  end
endmodule

// File: rtl/refsel_revtimer.sv
// Hold-off timer: counts minute ticks while one candidate stays best.
module refsel_revtimer #(
  parameter int              SEL_W    = 4,
  parameter int              DLY_W    = 8,
  parameter int              PRE_W    = 40,
  parameter logic [PRE_W-1:0] TICK_DIV = 40'd7500000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] cand_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             due_o
);
  logic             cand_vld_q, cand_vld_d;
  logic [SEL_W-1:0] cand_q, cand_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DLY_W-1:0] min_q, min_d;
  logic             same, tick;

  assign same = run_i && cand_vld_q && (cand_q == cand_i);
  assign tick = same && (pre_q == TICK_DIV - PRE_W'(1));

  always_comb begin
    cand_vld_d = cand_vld_q;
    cand_d     = cand_q;
    pre_d      = pre_q;
    min_d      = min_q;
    if (!same) begin
      cand_vld_d = run_i;
      cand_d     = cand_i;
      pre_d      = '0;
      min_d      = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick && (min_q != '1)) min_d = min_q + DLY_W'(1);
    end
  end

  assign due_o = run_i && ((same ? min_q : '0) >= delay_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_vld_q <= 1'b0;
      cand_q     <= '0;
      pre_q      <= '0;
      min_q      <= '0;
    end else begin
      cand_vld_q <= cand_vld_d;
      cand_q     <= cand_d;
      pre_q      <= pre_d;
      min_q      <= min_d;
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int              NREF     = 8,
  parameter int              PRIO_W   = 4,
  parameter int              DLY_W    = 8,
  parameter int              PRE_W    = 40,
  parameter logic [PRE_W-1:0] TICK_DIV = 40'd7500000000,
  localparam int             IDX_W    = $clog2(NREF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREF-1:0]        ref_qual_i,
  input  logic [NREF-1:0]        ref_mask_i,
  input  logic [NREF*PRIO_W-1:0] ref_prio_i,
  input  logic [PRIO_W-1:0]      fr_prio_i,
  input  logic                   auto_mode_i,
  input  logic                   revert_en_i,
  input  logic [DLY_W-1:0]       rev_delay_i,
  input  logic [1:0]             man_state_i,
  input  logic [IDX_W-1:0]       man_ref_i,
  input  logic                   hold_ok_i,
  output logic [1:0]             state_o,
  output logic [IDX_W-1:0]       active_ref_o,
  output logic                   los_o,
  output logic                   change_o
);
  import refsel_pkg::*;

  localparam int               SEL_W  = $clog2(NREF + 1);
  localparam logic [SEL_W-1:0] FR_SEL = SEL_W'(NREF);

  logic [NREF-1:0]   avail, elig;
  logic [PRIO_W-1:0] prio [NREF];

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    assign prio[g]  = ref_prio_i[g*PRIO_W +: PRIO_W];
    assign avail[g] = ref_qual_i[g] & ~ref_mask_i[g];
    assign elig[g]  = avail[g] && (prio[g] != '0);
  end

  logic             found;
  logic [SEL_W-1:0] best;

  refsel_pick #(.NREF(NREF), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_pick (
    .elig_i   (elig),
    .prio_i   (prio),
    .fr_prio_i(fr_prio_i),
    .found_o  (found),
    .best_o   (best)
  );

  op_state_e        state_q, state_d;
  logic [IDX_W-1:0] ref_q, ref_d;
  logic             frsel_q, frsel_d;
  logic             los_q, los_d;
  logic             chg_q, chg_d;

  logic             locked, sel_valid, cur_ok, run, due, man_bad;
  logic [SEL_W-1:0] cur_sel;

  assign locked    = (state_q == OP_LOCKED);
  assign sel_valid = locked || frsel_q;
  assign cur_sel   = locked ? SEL_W'(ref_q) : FR_SEL;
  assign cur_ok    = locked ? elig[ref_q] : (fr_prio_i != '0);
  assign run       = auto_mode_i && revert_en_i && sel_valid && cur_ok &&
                     found && (best != cur_sel);
  assign man_bad   = !auto_mode_i && (man_state_i == 2'd2) && !avail[man_ref_i];

  refsel_revtimer #(.SEL_W(SEL_W), .DLY_W(DLY_W), .PRE_W(PRE_W),
                    .TICK_DIV(TICK_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .cand_i (best),
    .delay_i(rev_delay_i),
    .due_o  (due)
  );

  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    frsel_d = frsel_q;
    if (!auto_mode_i) begin
      frsel_d = 1'b0;
      unique case (man_state_i)
        2'd0:    state_d = OP_FREERUN;
        2'd2: begin
          if (avail[man_ref_i]) begin
            state_d = OP_LOCKED;
            ref_d   = man_ref_i;
          end else begin
            state_d = OP_HOLDOVER;
          end
        end
        default: state_d = OP_HOLDOVER;
      endcase
    end else if (sel_valid && cur_ok) begin
      if (run && due) begin
        if (best == FR_SEL) begin
          state_d = OP_FREERUN;
          frsel_d = 1'b1;
        end else begin
          state_d = OP_LOCKED;
          ref_d   = best[IDX_W-1:0];
          frsel_d = 1'b0;
        end
      end
    end else if (found) begin
      if (best == FR_SEL) begin
        state_d = OP_FREERUN;
        frsel_d = 1'b1;
      end else begin
        state_d = OP_LOCKED;
        ref_d   = best[IDX_W-1:0];
        frsel_d = 1'b0;
      end
    end else begin
      state_d = hold_ok_i ? OP_HOLDOVER : OP_FREERUN;
      frsel_d = 1'b0;
    end
  end

  always_comb begin
    los_d = los_q;
    if (state_d == OP_LOCKED)
      los_d = 1'b0;
    else if ((locked && !avail[ref_q]) || man_bad)
      los_d = 1'b1;
    chg_d = (state_d != state_q) || (ref_d != ref_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_FREERUN;
      ref_q   <= '0;
      frsel_q <= 1'b0;
      los_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      frsel_q <= frsel_d;
      los_q   <= los_d;
      chg_q   <= chg_d;
    end
  end

  assign state_o      = state_q;
  assign active_ref_o = ref_q;
  assign los_o        = los_q;
  assign change_o     = chg_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
  parameter int NREF  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREF-1:0]  ref_qual_i,
  input logic [NREF-1:0]  ref_mask_i,
  input logic             auto_mode_i,
  input logic [1:0]       man_state_i,
  input logic [1:0]       state_o,
  input logic [IDX_W-1:0] active_ref_o,
  input logic             los_o,
  input logic             change_o
);
  logic [NREF-1:0] avail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= '0;
    else        avail_q <= ref_qual_i & ~ref_mask_i;
  end

  // R2
  locked_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> avail_q[active_ref_o]);

  // R12
  lock_clears_los_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> !los_o);

  // R11
  manual_freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode_i && man_state_i == 2'd0) |=> (state_o == 2'd0));

  // R13
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |-> (state_o != $past(state_o) || active_ref_o != $past(active_ref_o)));

  // R13
  cause_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o) || active_ref_o != $past(active_ref_o)) |-> change_o);

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

bind refsel_ctrl refsel_chk #(.NREF(NREF), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_qual_i  (ref_qual_i),
  .ref_mask_i  (ref_mask_i),
  .auto_mode_i (auto_mode_i),
  .man_state_i (man_state_i),
  .state_o     (state_o),
  .active_ref_o(active_ref_o),
  .los_o       (los_o),
  .change_o    (change_o)
);

// File: tb/sim_refsel_ctrl.sv
module sim_refsel_ctrl;
  localparam int NREF = 8;
  localparam int PW   = 4;
  localparam int TD   = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      qual, mask;
  logic [31:0]     prio_flat;
  logic [3:0]      fr;
  logic            auto_m, rev_en, hold;
  logic [7:0]      dly;
  logic [1:0]      mst;
  logic [2:0]      mref;
  logic [1:0]      st;
  logic [2:0]      aref;
  logic            los, chg;
  logic [3:0]      pr [8];

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) prio_flat[i*4 +: 4] = pr[i];

  refsel_ctrl #(.NREF(NREF), .PRIO_W(PW), .DLY_W(8), .PRE_W(40),
                .TICK_DIV(40'(TD))) u0 (
    .clk(clk), .rst_n(rst_n), .ref_qual_i(qual), .ref_mask_i(mask),
    .ref_prio_i(prio_flat), .fr_prio_i(fr), .auto_mode_i(auto_m),
    .revert_en_i(rev_en), .rev_delay_i(dly), .man_state_i(mst),
    .man_ref_i(mref), .hold_ok_i(hold), .state_o(st), .active_ref_o(aref),
    .los_o(los), .change_o(chg)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected autonomous pick from an empty selection
  task automatic model(input logic [7:0] q, input logic [7:0] m, input int frp,
                       input bit h, output int es, output int er);
    int bp = 0;
    bit f = 0;
    er = -1;
    for (int i = 0; i < 8; i++)
      if (q[i] && !m[i] && pr[i] != 0 && (!f || int'(pr[i]) < bp)) begin
        f = 1; bp = int'(pr[i]); er = i;
      end
    if (frp != 0 && (!f || frp < bp)) begin
      es = 0; er = -1;
    end else if (f) es = 2;
    else es = h ? 1 : 0;
  endtask

  task automatic clear();
    auto_m = 1'b0; mst = 2'd1;
    tick(1);
  endtask

  task automatic sweep(input string tag, input int frp);
    int es, er;
    for (int p = 0; p < 256; p++) begin
      clear();
      qual = 8'(p); hold = ^qual; fr = 4'(frp); auto_m = 1'b1;
      tick(1);
      model(qual, mask, frp, hold, es, er);
      chk(tag, int'(st), es);
      if (er >= 0) chk(tag, int'(aref), er);
    end
  endtask

  initial begin
    rst_n = 1'b0; qual = '0; mask = '0; fr = '0; auto_m = 1'b0; rev_en = 1'b0;
    dly = '0; mst = 2'd1; mref = '0; hold = 1'b1;
    for (int i = 0; i < 8; i++) pr[i] = '0;
    tick(3);
    chk("R1 state", int'(st), 0);
    chk("R1 ref", int'(aref), 0);
    chk("R1 los", int'(los), 0);
    chk("R1 strobe", int'(chg), 0);
    rst_n = 1'b1;
    tick(1);

    // R3 R5 R2: ranking with zero, ties and a masked entry
    pr[0] = 3; pr[1] = 1; pr[2] = 0; pr[3] = 2;
    pr[4] = 1; pr[5] = 5; pr[6] = 2; pr[7] = 0;
    mask = 8'h20;
    sweep("R3/R2/R5 sweep", 0);
    // R4: Free Run entry ties with priority 2
    mask = 8'h00;
    sweep("R4 sweep", 2);
    fr = 4'd0;

    // R7 R6 R13 R12
    for (int i = 0; i < 8; i++) pr[i] = '0;
    pr[0] = 1; pr[1] = 2; hold = 1'b1; rev_en = 1'b0;
    clear(); qual = 8'h02; auto_m = 1'b1; tick(1);
    chk("R3 lock ref1", int'(aref), 1);
    qual = 8'h03; tick(100);
    chk("R7 stays state", int'(st), 2);
    chk("R7 stays ref", int'(aref), 1);
    qual = 8'h01; tick(1);
    chk("R6 moved ref", int'(aref), 0);
    chk("R13 strobe high", int'(chg), 1);
    tick(1);
    chk("R13 strobe low", int'(chg), 0);
    qual = 8'h00; tick(1);
    chk("R12 holdover", int'(st), 1);
    chk("R12 alarm set", int'(los), 1);
    hold = 1'b0; tick(1);
    chk("R5 freerun when no hold", int'(st), 0);
    qual = 8'h01; hold = 1'b1; tick(1);
    chk("R12 relock", int'(st), 2);
    chk("R12 alarm clear", int'(los), 0);

    // R8 R10: delay of two minute ticks
    rev_en = 1'b1; dly = 8'd2;
    clear(); qual = 8'h02; auto_m = 1'b1; tick(1);
    qual = 8'h03; tick(2*TD - 2);
    chk("R10 before window", int'(aref), 1);
    tick(4);
    chk("R8 reverted", int'(aref), 0);
    chk("R8 locked", int'(st), 2);

    // R8: zero delay
    dly = 8'd0;
    clear(); qual = 8'h02; auto_m = 1'b1; tick(1);
    qual = 8'h03; tick(1);
    chk("R8 zero delay", int'(aref), 0);

    // R9: interrupted wait restarts
    dly = 8'd2;
    clear(); qual = 8'h02; auto_m = 1'b1; tick(1);
    qual = 8'h03; tick(30);
    qual = 8'h02; tick(1);
    chk("R9 during drop", int'(aref), 1);
    qual = 8'h03; tick(30);
    chk("R9 restarted", int'(aref), 1);
    tick(14);
    chk("R9 after restart", int'(aref), 0);
    rev_en = 1'b0;

    // R11 R2 R12: manual mode
    auto_m = 1'b0; qual = 8'hFF; mask = 8'h10;
    mst = 2'd2; mref = 3'd3; tick(1);
    chk("R11 manual lock", int'(st), 2);
    chk("R11 manual ref", int'(aref), 3);
    mref = 3'd4; tick(1);
    chk("R2 masked request", int'(st), 1);
    chk("R12 manual alarm", int'(los), 1);
    mst = 2'd0; tick(1);
    chk("R11 manual freerun", int'(st), 0);
    mst = 2'd3; tick(1);
    chk("R11 code 3", int'(st), 1);
    mask = 8'h00;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 2; k++) begin
        qual = (k == 0) ? 8'hA5 : 8'h5A;
        mst = 2'd2; mref = 3'(r); tick(1);
        chk("R11 manual sweep", int'(st), qual[r] ? 2 : 1);
        if (qual[r]) chk("R11 manual sweep ref", int'(aref), r);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule